// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block drives up to four pulse-width-modulated outputs that share one period. A prescaler divides the input clock into a local tick. A counter of CNT_W bits, 8 by default, advances once per tick. Every channel compares the counter against its own duty value. The period is therefore always 2^CNT_W ticks. The only way to change it is through the 8-bit prescale value.

Software programs the block through a simple register write port and reads it back through a combinational read port. A write to a duty register or to the prescale field lands in a shadow copy. The counter copies the shadow values into its working set only at the end of a period, so a change made in mid-period never gives a cut-short or malformed pulse. One common enable bit starts and stops all channels together.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every output is low and every register reads back as zero.
- R2: The duty register of channel i sits at byte address 4*i and holds CNT_W bits. The control register sits at byte address 0x50, with the prescale low nibble in bits 3:0, the enable in bit 9 and the prescale high nibble in bits 14:11. A read returns the last written shadow value, with every other bit zero.
- R3: The counter advances once every P+1 clock cycles, where the prescale P = {ctrl[14:11], ctrl[3:0]} ranges from 0 to 255.
- R4: The counter runs from 0 to 2^CNT_W-1 and wraps to 0, so each period lasts 2^CNT_W*(P+1) clock cycles.
- R5: A channel with duty N is high while the count is at most N. Its output goes high at count 0 and stays high for N+1 ticks. A duty of 0 gives a single tick, and the all-ones duty gives an output that never goes low.
- R6: While the enable bit is clear, all outputs are low and the counter and prescaler are held at zero. Setting the bit starts a fresh period at count 0 on the next cycle.
- R7: Duty and prescale writes made while enabled take effect only at the next counter wrap. While disabled, they take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data at addr |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The bench builds the block with CNT_W = 4 and four channels. A full period is then only 16 ticks, so every cycle of several whole periods can be compared against a count derived arithmetically from the prescale. Under that setting, duties of 0 and 15 reach the single-tick and always-high extremes in a few cycles. A prescale with a nonzero high nibble checks the split field within a 272-cycle period. A mid-period rewrite of duty and prescale checks the switch exactly at the wrap.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(8'h50);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  logic [NCH-1:0][CNT_W-1:0] duty_sh, duty_act;
  logic [7:0]       ps_sh, ps_act, pre;
  logic             en;
  logic [CNT_W-1:0] cnt;

  wire unused_bits = ^wdata;
  wire ctrl_hit = wr_en && (addr == CTRL_ADDR);
  wire tick     = (pre == ps_act);
  wire wrap     = en && tick && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_sh <= '0;
      en    <= 1'b0;
    end else if (ctrl_hit) begin
      ps_sh <= {wdata[14:11], wdata[3:0]};
      en    <= wdata[9];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_sh <= '0;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (wr_en && addr == ADDR_W'(4 * i)) duty_sh[i] <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre      <= '0;
      cnt      <= '0;
      ps_act   <= '0;
      duty_act <= '0;
    end else if (!en) begin
      pre      <= '0;
      cnt      <= '0;
      ps_act   <= ps_sh;
      duty_act <= duty_sh;
    end else if (tick) begin
      pre <= '0;
      cnt <= cnt + 1'b1;
      if (cnt == CNT_MAX) begin
        ps_act   <= ps_sh;
        duty_act <= duty_sh;
      end
    end else begin
      pre <= pre + 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign pwm_out[g] = en && (cnt <= duty_act[g]);

    a_r5_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
      (en && duty_act[g] == CNT_MAX) |-> pwm_out[g]);
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) begin
      rdata[14:11] = ps_sh[7:4];
      rdata[9]     = en;
      rdata[3:0]   = ps_sh[3:0];
    end
    for (int i = 0; i < NCH; i++)
      if (addr == ADDR_W'(4 * i)) rdata[CNT_W-1:0] = duty_sh[i];
  end

  a_r6_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm_out == '0));

  a_r6_restart_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && pre == '0));

  a_r5_high_at_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == '0) |-> (pwm_out == '1));

  a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(duty_act) && $stable(ps_act)));

  a_r3_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pre <= ps_act));
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb_top;
  localparam int NCH = 4, CW = 4, AW = 7, PER = 16;
  localparam logic [AW-1:0] CTRL = 7'h50;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] pwm_out;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  pwm_bank #(.NCH(NCH), .CNT_W(CW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  function automatic logic [31:0] ctrlw(input int p, input bit e);
    return (32'(p >> 4) << 11) | (32'(e) << 9) | 32'(p & 15);
  endfunction

  function automatic logic [NCH-1:0] model(input int cnt, input logic [15:0] d);
    logic [NCH-1:0] o;
    for (int i = 0; i < NCH; i++) o[i] = (cnt <= int'(d[4*i +: 4]));
    return o;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic setup(input int p, input logic [15:0] d);
    wr(CTRL, ctrlw(p, 0));
    for (int i = 0; i < NCH; i++) wr(AW'(4 * i), 32'(d[4*i +: 4]));
    wr(CTRL, ctrlw(p, 1));
  endtask

  // Runs n cycles from a fresh enable; optionally rewrites duty/prescale mid-period.
  task automatic run(input string req, input int n, input int p0, input logic [15:0] da,
                     input bit chg, input int p1, input logic [15:0] db);
    for (int t = 0; t < n; t++) begin
      int cnt;
      logic [15:0] d;
      wr_en = 0;
      if (!chg || t < PER * (p0 + 1)) begin
        cnt = (t / (p0 + 1)) % PER; d = da;
      end else begin
        cnt = ((t - PER * (p0 + 1)) / (p1 + 1)) % PER; d = db;
      end
      chk(req, 32'(pwm_out), 32'(model(cnt, d)));
      if (chg && t == 5) begin addr = 0; wdata = 32'(db[3:0]); wr_en = 1; end
      if (chg && t == 6) begin addr = 4; wdata = 32'(db[7:4]); wr_en = 1; end
      if (chg && t == 7) begin addr = CTRL; wdata = ctrlw(p1, 1); wr_en = 1; end
      @(negedge clk);
    end
    wr_en = 0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outputs", 32'(pwm_out), 0);
    rd("R1 ctrl", CTRL, 0);
    rd("R1 duty", 12, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: readback and field placement
    wr(CTRL, 32'hFFFF_FDFF);
    rd("R2 ctrl fields", CTRL, 32'h0000_780F);
    wr(8, 32'hFFFF_FFF9);
    rd("R2 duty width", 8, 32'h9);
    rd("R2 unmapped", 7'h20, 0);

    // R4 R5: full sweeps at prescale 0, incl. duty 0 and all-ones
    setup(0, 16'hF_E_5_0);
    run("R4 R5 p0", 2 * PER, 0, 16'hF_E_5_0, 0, 0, 0);
    // R3: prescale 2
    setup(2, 16'h9_7_3_F);
    run("R3 p2", 2 * PER * 3, 2, 16'h9_7_3_F, 0, 0, 0);
    // R3: high nibble of prescale (P = 0x10)
    setup(16, 16'h1_8_0_C);
    run("R3 p16 split", PER * 17 + 40, 16, 16'h1_8_0_C, 0, 0, 0);

    // R6: disable mid-period, then restart from zero
    setup(0, 16'h6_6_6_6);
    run("R6 before off", 7, 0, 16'h6_6_6_6, 0, 0, 0);
    wr(CTRL, ctrlw(0, 0));
    for (int k = 0; k < 5; k++) begin
      chk("R6 off low", 32'(pwm_out), 0);
      @(negedge clk);
    end
    wr(CTRL, ctrlw(0, 1));
    run("R6 restart", PER + 4, 0, 16'h6_6_6_6, 0, 0, 0);

    // R7: shadow update lands at the wrap only
    setup(0, 16'h3_3_3_3);
    run("R7 shadow", PER + 2 * PER * 2, 0, 16'h3_3_3_3, 1, 1, 16'h3_3_C_A);
    rd("R7 shadow readback", 0, 32'hA);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule